// File: doc/BRIEF.md
# Tagged I/O Translation Cache with Ranged Invalidation

This block is a small fully associative cache of finished address translations for an I/O memory management unit. Each slot is keyed by four fields: an address-space identifier, a two-bit granule code, a two-bit walk level and a page-aligned input address. Each slot stores an output address, an offset mask and two permission bits. A table walker outside the block fills slots through the insert port. Translation requests arrive on the lookup port. Software-driven maintenance uses the invalidation port to drop stale slots.

The lookup, insert and invalidation request ports are valid/ready. A request is taken on a rising edge where its valid and ready are both high. The requester holds valid and its fields stable until that edge. Ready never depends on the result path. When several ports are valid in one cycle, invalidation is taken first, then insert, then lookup. An accepted invalidation starts a sweep that examines one slot per cycle. While the sweep runs, all three ready outputs are low.

The lookup result is a registered one-cycle pulse and cannot be back-pressured. When no result is present, its data fields read zero. Two saturating counters record lookup hits and misses.

Top module: `iotlb_cache`

## Requirements
- R1: A lookup hits only when a valid slot matches all four key fields. The result pulse `rs_valid` is high in the second cycle after the acceptance edge and carries that slot's output, mask and permissions.
- R2: Before comparing, a lookup clears the page-offset bits of its address. With granule size exponent g = 2*tg+10 and shift s = g + (3-level)*(g-3), the mask is (1<<s)-1, or all ones when s is at least the address width. Codes: tg 1, 2 and 3 mean 4 KB, 16 KB and 64 KB.
- R3: A lookup misses, and returns zero data, when the ASID, the granule code or the level differs from every stored slot.
- R4: An insert taken while every slot is valid first drops all slots and then writes the new entry, which leaves exactly one valid slot.
- R5: An insert whose key equals a valid slot's key overwrites that slot, so no key is ever held twice.
- R6: Invalidation kind 0 removes every slot, and reset also leaves no valid slot.
- R7: Invalidation kind 1 removes exactly the slots whose ASID equals `inv_asid`.
- R8: Invalidation kind 2 with a nonzero `inv_ttl` and `inv_pages` equal to 1 removes only the slot whose key is exactly {inv_asid, inv_addr, inv_tg, inv_ttl}. Overlapping slots are kept, and `inv_any_asid` is ignored.
- R9: Any other kind 2 request is a range removal. The range granule exponent is 2*tg+10, or 12 when tg is 0. The range mask is (inv_pages << exponent)-1. A slot is removed when its ASID matches (or `inv_any_asid` is high) and either (inv_addr & ~slot mask) equals the slot address, or (slot address & ~range mask) equals inv_addr. Kind 3 removes nothing.
- R10: An accepted invalidation keeps all ready outputs low for ENTRIES cycles. `inv_done` pulses for one cycle as the sweep ends, and the ready outputs return in that same cycle.
- R11: `hit_cnt` and `miss_cnt` each add one per hit or miss result and stop at their all-ones value.
- R12: With several requests valid together, invalidation is taken before insert and insert before lookup. The later ones wait with ready low.
- R13: After reset, counters and result outputs are zero and the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_asid | input | ASID_W | Lookup ASID |
| lk_addr | input | ADDR_W | Lookup input address (offset bits ignored) |
| lk_tg | input | 2 | Lookup granule code |
| lk_level | input | 2 | Lookup walk level |
| rs_valid | output | 1 | Result pulse |
| rs_hit | output | 1 | Result is a hit |
| rs_out | output | OUT_W | Hit output address, zero otherwise |
| rs_mask | output | ADDR_W | Hit offset mask, zero otherwise |
| rs_perm | output | 2 | Hit permissions, zero otherwise |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert can be taken |
| ins_asid | input | ASID_W | Insert ASID |
| ins_addr | input | ADDR_W | Insert page-aligned input address |
| ins_tg | input | 2 | Insert granule code |
| ins_level | input | 2 | Insert walk level |
| ins_out | input | OUT_W | Insert output address |
| ins_mask | input | ADDR_W | Insert offset mask |
| ins_perm | input | 2 | Insert permissions |
| inv_valid | input | 1 | Invalidation request valid |
| inv_ready | output | 1 | Invalidation can be taken |
| inv_kind | input | 2 | 0 all, 1 by ASID, 2 by address, 3 none |
| inv_asid | input | ASID_W | Invalidation ASID |
| inv_any_asid | input | 1 | Range removal ignores ASID |
| inv_addr | input | ADDR_W | Invalidation address |
| inv_tg | input | 2 | Invalidation granule code |
| inv_ttl | input | 2 | Level hint, 0 means none |
| inv_pages | input | PAGES_W | Page count |
| inv_done | output | 1 | Sweep finished pulse |
| hit_cnt | output | CNT_W | Saturating hit count |
| miss_cnt | output | CNT_W | Saturating miss count |

## Verification
The bound checker checks these properties on every cycle:
- all ready outputs stay low while a sweep runs;
- `inv_done` marks the end of a sweep;
- a lookup result follows two edges after acceptance;
- a full insert leaves a single valid slot;
- at most one slot hits any lookup;
- the counters never step back.

Other behaviour can only be shown by the bench's scenarios against its behavioural model:
- which slots each invalidation form removes, including both overlap directions, the wildcard ASID and the exact-key case;
- the offset masking for each granule and level;
- overwrite on a repeated key;
- counter saturation.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_ADDR = 2'd2,
    INV_NONE = 2'd3
  } inv_kind_e;

  // offset bits covered by one translation at (tg, level)
  function automatic int page_shift(input logic [1:0] tg, input logic [1:0] lvl);
    int g;
    g = 2 * int'(tg) + 10;
    return g + (3 - int'(lvl)) * (g - 3);
  endfunction

  // granule exponent used to scale a page count in range removal
  function automatic int range_shift(input logic [1:0] tg);
    return (tg == 2'd0) ? 12 : 2 * int'(tg) + 10;
  endfunction

endpackage

// File: rtl/iotlb_key_cmp.sv
module iotlb_key_cmp #(
  parameter int ASID_W = 16,
  parameter int ADDR_W = 48
) (
  input  logic              e_v,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [1:0]        e_tg,
  input  logic [1:0]        e_lvl,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic [ADDR_W-1:0] e_mask,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [1:0]        q_tg,
  input  logic [1:0]        q_lvl,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [ASID_W-1:0] n_asid,
  input  logic [1:0]        n_tg,
  input  logic [1:0]        n_lvl,
  input  logic [ADDR_W-1:0] n_addr,
  input  logic [1:0]        i_kind,
  input  logic              i_exact,
  input  logic              i_any,
  input  logic [ASID_W-1:0] i_asid,
  input  logic [1:0]        i_tg,
  input  logic [1:0]        i_ttl,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic [ADDR_W-1:0] i_rmask,
  output logic              lk_hit,
  output logic              ins_hit,
  output logic              inv_kill
);
  import iotlb_pkg::*;

  assign lk_hit  = e_v && (e_asid == q_asid) && (e_tg == q_tg) &&
                   (e_lvl == q_lvl) && (e_addr == q_addr);
  assign ins_hit = e_v && (e_asid == n_asid) && (e_tg == n_tg) &&
                   (e_lvl == n_lvl) && (e_addr == n_addr);

  logic asid_ok, inside_entry, entry_inside;
  assign asid_ok      = i_any || (e_asid == i_asid);
  assign inside_entry = (i_addr & ~e_mask) == e_addr;
  assign entry_inside = (e_addr & ~i_rmask) == i_addr;

  always_comb begin
    inv_kill = 1'b0;
    case (i_kind)
      INV_ALL:  inv_kill = e_v;
      INV_ASID: inv_kill = e_v && (e_asid == i_asid);
      INV_ADDR: begin
        if (i_exact)
          inv_kill = e_v && (e_asid == i_asid) && (e_tg == i_tg) &&
                     (e_lvl == i_ttl) && (e_addr == i_addr);
        else
          inv_kill = e_v && asid_ok && (inside_entry || entry_inside);
      end
      default:  inv_kill = 1'b0;
    endcase
  end
endmodule

// File: rtl/iotlb_sweep.sv
module iotlb_sweep #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iotlb_sat_ctr.sv
module iotlb_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (inc && ~&cnt)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 16,
  parameter int ADDR_W  = 48,
  parameter int OUT_W   = 48,
  parameter int PAGES_W = 16,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [ADDR_W-1:0]  lk_addr,
  input  logic [1:0]         lk_tg,
  input  logic [1:0]         lk_level,
  output logic               rs_valid,
  output logic               rs_hit,
  output logic [OUT_W-1:0]   rs_out,
  output logic [ADDR_W-1:0]  rs_mask,
  output logic [1:0]         rs_perm,
  input  logic               ins_valid,
  output logic               ins_ready,
  input  logic [ASID_W-1:0]  ins_asid,
  input  logic [ADDR_W-1:0]  ins_addr,
  input  logic [1:0]         ins_tg,
  input  logic [1:0]         ins_level,
  input  logic [OUT_W-1:0]   ins_out,
  input  logic [ADDR_W-1:0]  ins_mask,
  input  logic [1:0]         ins_perm,
  input  logic               inv_valid,
  output logic               inv_ready,
  input  logic [1:0]         inv_kind,
  input  logic [ASID_W-1:0]  inv_asid,
  input  logic               inv_any_asid,
  input  logic [ADDR_W-1:0]  inv_addr,
  input  logic [1:0]         inv_tg,
  input  logic [1:0]         inv_ttl,
  input  logic [PAGES_W-1:0] inv_pages,
  output logic               inv_done,
  output logic [CNT_W-1:0]   hit_cnt,
  output logic [CNT_W-1:0]   miss_cnt
);
  import iotlb_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [ADDR_W-1:0] page_mask(input logic [1:0] tg, input logic [1:0] lvl);
    int s;
    s = page_shift(tg, lvl);
    if (s >= ADDR_W) return '1;
    return (ADDR_W'(1) << s) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] range_mask(input logic [PAGES_W-1:0] n, input logic [1:0] tg);
    logic [63:0] w;
    w = (64'(n) << range_shift(tg)) - 64'd1;
    return w[ADDR_W-1:0];
  endfunction

  // slot storage
  logic [ENTRIES-1:0] ev;
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [1:0]         e_tg   [ENTRIES];
  logic [1:0]         e_lvl  [ENTRIES];
  logic [ADDR_W-1:0]  e_addr [ENTRIES];
  logic [ADDR_W-1:0]  e_mask [ENTRIES];
  logic [OUT_W-1:0]   e_out  [ENTRIES];
  logic [1:0]         e_perm [ENTRIES];

  // handshakes, fixed priority inv > ins > lookup
  logic busy, inv_acc, ins_acc, lk_acc;
  assign inv_ready = !busy;
  assign ins_ready = !busy && !inv_valid;
  assign lk_ready  = !busy && !inv_valid && !ins_valid;
  assign inv_acc   = inv_valid && inv_ready;
  assign ins_acc   = ins_valid && ins_ready;
  assign lk_acc    = lk_valid && lk_ready;

  // latched invalidation request
  logic [1:0]         iq_kind, iq_tg, iq_ttl;
  logic               iq_exact, iq_any;
  logic [ASID_W-1:0]  iq_asid;
  logic [ADDR_W-1:0]  iq_addr, iq_rmask;

  always_ff @(posedge clk) begin
    if (inv_acc) begin
      iq_kind  <= inv_kind;
      iq_exact <= (inv_ttl != 2'd0) && (inv_pages == PAGES_W'(1));
      iq_any   <= inv_any_asid;
      iq_asid  <= inv_asid;
      iq_tg    <= inv_tg;
      iq_ttl   <= inv_ttl;
      iq_addr  <= inv_addr;
      iq_rmask <= range_mask(inv_pages, inv_tg);
    end
  end

  // registered lookup query, offset bits already cleared
  logic               lq_v;
  logic [ASID_W-1:0]  lq_asid;
  logic [1:0]         lq_tg, lq_lvl;
  logic [ADDR_W-1:0]  lq_addr;

  always_ff @(posedge clk) begin
    if (rst) lq_v <= 1'b0;
    else     lq_v <= lk_acc;
    if (lk_acc) begin
      lq_asid <= lk_asid;
      lq_tg   <= lk_tg;
      lq_lvl  <= lk_level;
      lq_addr <= lk_addr & ~page_mask(lk_tg, lk_level);
    end
  end

  // per-slot comparators
  logic [ENTRIES-1:0] lk_hit, ins_hit, kill;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    iotlb_key_cmp #(.ASID_W(ASID_W), .ADDR_W(ADDR_W)) u_cmp (
      .e_v(ev[g]), .e_asid(e_asid[g]), .e_tg(e_tg[g]), .e_lvl(e_lvl[g]),
      .e_addr(e_addr[g]), .e_mask(e_mask[g]),
      .q_asid(lq_asid), .q_tg(lq_tg), .q_lvl(lq_lvl), .q_addr(lq_addr),
      .n_asid(ins_asid), .n_tg(ins_tg), .n_lvl(ins_level), .n_addr(ins_addr),
      .i_kind(iq_kind), .i_exact(iq_exact), .i_any(iq_any), .i_asid(iq_asid),
      .i_tg(iq_tg), .i_ttl(iq_ttl), .i_addr(iq_addr), .i_rmask(iq_rmask),
      .lk_hit(lk_hit[g]), .ins_hit(ins_hit[g]), .inv_kill(kill[g])
    );
  end

  // sweep sequencer
  logic [IDX_W-1:0] sw_idx;
  iotlb_sweep #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst(rst), .start(inv_acc), .busy(busy), .idx(sw_idx), .done(inv_done)
  );

  // insert slot choice: same key first, else lowest free; full -> slot 0
  logic             full, found;
  logic [IDX_W-1:0] slot, wslot;
  assign full = &ev;

  always_comb begin
    slot  = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && ins_hit[i]) begin slot = IDX_W'(i); found = 1'b1; end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !ev[i]) begin slot = IDX_W'(i); found = 1'b1; end
  end
  assign wslot = full ? '0 : slot;

  always_ff @(posedge clk) begin
    if (rst)                    ev <= '0;
    else if (ins_acc) begin
      if (full)                 ev <= ENTRIES'(1);
      else                      ev[slot] <= 1'b1;
    end else if (busy && kill[sw_idx])
                                ev[sw_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (ins_acc) begin
      e_asid[wslot] <= ins_asid;
      e_tg[wslot]   <= ins_tg;
      e_lvl[wslot]  <= ins_level;
      e_addr[wslot] <= ins_addr;
      e_mask[wslot] <= ins_mask;
      e_out[wslot]  <= ins_out;
      e_perm[wslot] <= ins_perm;
    end
  end

  // result stage
  logic [ENTRIES-1:0] hitv;
  logic               any_hit;
  logic [OUT_W-1:0]   sel_out;
  logic [ADDR_W-1:0]  sel_mask;
  logic [1:0]         sel_perm;
  assign hitv = lk_hit & {ENTRIES{lq_v}};

  always_comb begin
    any_hit  = |hitv;
    sel_out  = '0;
    sel_mask = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitv[i]) begin
        sel_out  = sel_out  | e_out[i];
        sel_mask = sel_mask | e_mask[i];
        sel_perm = sel_perm | e_perm[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_out   <= '0;
      rs_mask  <= '0;
      rs_perm  <= '0;
    end else begin
      rs_valid <= lq_v;
      rs_hit   <= any_hit;
      rs_out   <= sel_out;
      rs_mask  <= sel_mask;
      rs_perm  <= sel_perm;
    end
  end

  iotlb_sat_ctr #(.W(CNT_W)) u_hits (
    .clk(clk), .rst(rst), .inc(any_hit), .cnt(hit_cnt)
  );
  iotlb_sat_ctr #(.W(CNT_W)) u_miss (
    .clk(clk), .rst(rst), .inc(lq_v && !any_hit), .cnt(miss_cnt)
  );
endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               ins_valid,
  input logic               ins_ready,
  input logic               inv_valid,
  input logic               inv_ready,
  input logic               rs_valid,
  input logic               inv_done,
  input logic               busy,
  input logic               full,
  input logic [ENTRIES-1:0] ev,
  input logic [ENTRIES-1:0] hitv,
  input logic [CNT_W-1:0]   hit_cnt,
  input logic [CNT_W-1:0]   miss_cnt
);
  // R1
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |-> ##2 rs_valid);
  // R4
  p_flush_r4: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_ready && full) |=> ($countones(ev) == 1));
  // R5
  p_unique_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitv));
  // R10
  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!lk_ready && !ins_ready && !inv_ready));
  // R10
  p_done_r10: assert property (@(posedge clk) disable iff (rst)
    inv_done |-> (!busy && $past(busy)));
  // R11
  p_mono_r11: assert property (@(posedge clk) disable iff (rst)
    (hit_cnt >= $past(hit_cnt)) && (miss_cnt >= $past(miss_cnt)));
  // R12
  p_prio_r12: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_ready) |-> (!ins_ready && !lk_ready));
endmodule

bind iotlb_cache iotlb_cache_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .ins_valid(ins_valid), .ins_ready(ins_ready), .inv_valid(inv_valid),
  .inv_ready(inv_ready), .rs_valid(rs_valid), .inv_done(inv_done),
  .busy(busy), .full(full), .ev(ev), .hitv(hitv),
  .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
);

// File: tb/iotlb_cache_tb_top.sv
module iotlb_cache_tb_top;
  localparam int E = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        lk_valid = 0, lk_ready;
  logic [15:0] lk_asid = 0;
  logic [47:0] lk_addr = 0;
  logic [1:0]  lk_tg = 0, lk_level = 0;
  logic        rs_valid, rs_hit;
  logic [47:0] rs_out, rs_mask;
  logic [1:0]  rs_perm;
  logic        ins_valid = 0, ins_ready;
  logic [15:0] ins_asid = 0;
  logic [47:0] ins_addr = 0, ins_out = 0, ins_mask = 0;
  logic [1:0]  ins_tg = 0, ins_level = 0, ins_perm = 0;
  logic        inv_valid = 0, inv_ready, inv_any_asid = 0, inv_done;
  logic [1:0]  inv_kind = 0, inv_tg = 0, inv_ttl = 0;
  logic [15:0] inv_asid = 0, inv_pages = 0;
  logic [47:0] inv_addr = 0;
  logic [CW-1:0] hit_cnt, miss_cnt;

  iotlb_cache #(.ENTRIES(E), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_asid(lk_asid), .lk_addr(lk_addr),
    .lk_tg(lk_tg), .lk_level(lk_level),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_out(rs_out), .rs_mask(rs_mask), .rs_perm(rs_perm),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_asid(ins_asid), .ins_addr(ins_addr),
    .ins_tg(ins_tg), .ins_level(ins_level), .ins_out(ins_out), .ins_mask(ins_mask),
    .ins_perm(ins_perm),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_kind(inv_kind), .inv_asid(inv_asid),
    .inv_any_asid(inv_any_asid), .inv_addr(inv_addr), .inv_tg(inv_tg), .inv_ttl(inv_ttl),
    .inv_pages(inv_pages), .inv_done(inv_done),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic [15:0] asid; logic [1:0] tg; logic [1:0] lvl;
    logic [47:0] addr; logic [47:0] mask; logic [47:0] out; logic [1:0] perm;
  } ment_t;

  ment_t tbl[$];
  int    left = 0;
  bit    m_done = 0, p_v = 0, p_hit = 0;
  ment_t p_ent;
  bit    m_rv = 0, m_rh = 0;
  logic [47:0] m_out = 0, m_mask = 0;
  logic [1:0]  m_perm = 0;
  int    m_hc = 0, m_mc = 0;
  int    vectors = 0, miscompares = 0;
  string cur_req = "R13";

  function automatic logic [47:0] offs_mask(input int tg, input int lv);
    int g, s;
    g = 2 * tg + 10;
    s = g + (3 - lv) * (g - 3);
    if (s >= 48) return '1;
    return (48'(1) << s) - 48'(1);
  endfunction

  function automatic bit removes(input ment_t e);
    longint unsigned wm;
    logic [47:0] rm;
    int gexp;
    if (inv_kind == 2'd0) return 1;
    if (inv_kind == 2'd1) return e.asid == inv_asid;
    if (inv_kind == 2'd3) return 0;
    if (inv_ttl != 0 && inv_pages == 16'd1)
      return e.asid == inv_asid && e.tg == inv_tg && e.lvl == inv_ttl && e.addr == inv_addr;
    gexp = (inv_tg == 0) ? 12 : 2 * int'(inv_tg) + 10;
    wm = (longint'(inv_pages) << gexp) - 1;
    rm = wm[47:0];
    if (!inv_any_asid && e.asid != inv_asid) return 0;
    return ((inv_addr & ~e.mask) == e.addr) || ((e.addr & ~rm) == inv_addr);
  endfunction

  always @(posedge clk) begin
    bit busy_pre;
    if (rst) begin
      tbl.delete(); left = 0; m_done = 0; p_v = 0; p_hit = 0;
      m_rv = 0; m_rh = 0; m_out = 0; m_mask = 0; m_perm = 0; m_hc = 0; m_mc = 0;
    end else begin
      busy_pre = (left > 0);
      m_rv = p_v; m_rh = p_v && p_hit;
      m_out  = m_rh ? p_ent.out  : 48'd0;
      m_mask = m_rh ? p_ent.mask : 48'd0;
      m_perm = m_rh ? p_ent.perm : 2'd0;
      if (p_v && p_hit && m_hc < (1 << CW) - 1) m_hc++;
      if (p_v && !p_hit && m_mc < (1 << CW) - 1) m_mc++;
      m_done = 0;
      if (left > 0) begin left--; if (left == 0) m_done = 1; end
      p_v = 0; p_hit = 0;
      if (!busy_pre && inv_valid) begin
        for (int i = tbl.size() - 1; i >= 0; i--) if (removes(tbl[i])) tbl.delete(i);
        left = E;
      end else if (!busy_pre && ins_valid) begin
        ment_t n;
        bit rep;
        n.asid = ins_asid; n.tg = ins_tg; n.lvl = ins_level; n.addr = ins_addr;
        n.mask = ins_mask; n.out = ins_out; n.perm = ins_perm;
        rep = 0;
        if (tbl.size() == E) tbl.delete();
        else for (int i = 0; i < tbl.size(); i++)
          if (!rep && tbl[i].asid == n.asid && tbl[i].tg == n.tg && tbl[i].lvl == n.lvl &&
              tbl[i].addr == n.addr) begin tbl[i] = n; rep = 1; end
        if (!rep) tbl.push_back(n);
      end else if (!busy_pre && lk_valid) begin
        logic [47:0] qa;
        qa = lk_addr & ~offs_mask(int'(lk_tg), int'(lk_level));
        p_v = 1;
        for (int i = 0; i < tbl.size(); i++)
          if (tbl[i].asid == lk_asid && tbl[i].tg == lk_tg && tbl[i].lvl == lk_level &&
              tbl[i].addr == qa) begin p_hit = 1; p_ent = tbl[i]; end
      end
    end
  end

  task automatic chk(input string nm, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got=%0h exp=%0h t=%0t", cur_req, nm, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      chk("inv_ready", 64'(inv_ready), 64'(left == 0));
      chk("ins_ready", 64'(ins_ready), 64'(left == 0 && !inv_valid));
      chk("lk_ready",  64'(lk_ready),  64'(left == 0 && !inv_valid && !ins_valid));
      chk("inv_done",  64'(inv_done),  64'(m_done));
      chk("rs_valid",  64'(rs_valid),  64'(m_rv));
      chk("rs_hit",    64'(rs_hit),    64'(m_rh));
      chk("rs_out",    64'(rs_out),    64'(m_out));
      chk("rs_mask",   64'(rs_mask),   64'(m_mask));
      chk("rs_perm",   64'(rs_perm),   64'(m_perm));
      chk("hit_cnt",   64'(hit_cnt),   64'(m_hc));
      chk("miss_cnt",  64'(miss_cnt),  64'(m_mc));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lookup(input logic [15:0] a, input logic [47:0] ad,
                        input logic [1:0] tg, input logic [1:0] lv);
    @(negedge clk);
    lk_valid = 1; lk_asid = a; lk_addr = ad; lk_tg = tg; lk_level = lv;
    #1; while (!lk_ready) begin @(negedge clk); #1; end
    @(negedge clk); lk_valid = 0;
  endtask

  task automatic insert(input logic [15:0] a, input logic [47:0] ad, input logic [1:0] tg,
                        input logic [1:0] lv, input logic [47:0] o, input logic [1:0] pm);
    @(negedge clk);
    ins_valid = 1; ins_asid = a; ins_addr = ad; ins_tg = tg; ins_level = lv;
    ins_out = o; ins_perm = pm; ins_mask = offs_mask(int'(tg), int'(lv));
    #1; while (!ins_ready) begin @(negedge clk); #1; end
    @(negedge clk); ins_valid = 0;
  endtask

  task automatic inv_go(input logic [1:0] k, input logic [15:0] a, input bit any,
                        input logic [47:0] ad, input logic [1:0] tg, input logic [1:0] ttl,
                        input logic [15:0] pg);
    @(negedge clk);
    inv_valid = 1; inv_kind = k; inv_asid = a; inv_any_asid = any; inv_addr = ad;
    inv_tg = tg; inv_ttl = ttl; inv_pages = pg;
    #1; while (!inv_ready) begin @(negedge clk); #1; end
    @(negedge clk); inv_valid = 0;
  endtask

  task automatic inv(input logic [1:0] k, input logic [15:0] a, input bit any,
                     input logic [47:0] ad, input logic [1:0] tg, input logic [1:0] ttl,
                     input logic [15:0] pg);
    inv_go(k, a, any, ad, tg, ttl, pg);
    idle(E + 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog got=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    cur_req = "R13"; idle(2);
    lookup(16'd5, 48'h1000, 2'd1, 2'd3); idle(3);

    cur_req = "R1";
    insert(16'd5, 48'h1000, 2'd1, 2'd3, 48'hAB000, 2'd3);
    lookup(16'd5, 48'h1000, 2'd1, 2'd3); idle(3);
    cur_req = "R2";
    lookup(16'd5, 48'h1ABC, 2'd1, 2'd3); idle(3);
    insert(16'd5, 48'h0, 2'd3, 2'd2, 48'h2000_0000, 2'd1);     // 64K level 2: 512 MB page
    lookup(16'd5, 48'h1234_5678, 2'd3, 2'd2); idle(3);
    cur_req = "R3";
    lookup(16'd6, 48'h1000, 2'd1, 2'd3);
    lookup(16'd5, 48'h1000, 2'd2, 2'd3);
    lookup(16'd5, 48'h1000, 2'd1, 2'd2); idle(3);

    cur_req = "R5";
    insert(16'd5, 48'h1000, 2'd1, 2'd3, 48'hCD000, 2'd2);
    lookup(16'd5, 48'h1000, 2'd1, 2'd3); idle(3);
    cur_req = "R4";
    insert(16'd8, 48'h8000, 2'd1, 2'd3, 48'h1, 2'd1);
    insert(16'd9, 48'h9000, 2'd1, 2'd3, 48'h2, 2'd1);
    insert(16'd10, 48'hA000, 2'd1, 2'd3, 48'h3, 2'd1);
    lookup(16'd5, 48'h1000, 2'd1, 2'd3);
    lookup(16'd10, 48'hA000, 2'd1, 2'd3); idle(3);

    cur_req = "R6";
    inv(2'd0, 16'd0, 1'b0, 48'd0, 2'd0, 2'd0, 16'd0);
    lookup(16'd10, 48'hA000, 2'd1, 2'd3);
    lookup(16'd11, 48'hB000, 2'd1, 2'd3); idle(3);

    cur_req = "R7";
    insert(16'd1, 48'h3000, 2'd1, 2'd3, 48'h31000, 2'd3);
    insert(16'd2, 48'h3000, 2'd1, 2'd3, 48'h32000, 2'd3);
    inv(2'd1, 16'd1, 1'b0, 48'd0, 2'd0, 2'd0, 16'd0);
    lookup(16'd1, 48'h3000, 2'd1, 2'd3);
    lookup(16'd2, 48'h3000, 2'd1, 2'd3); idle(3);

    cur_req = "R8";
    inv(2'd0, 16'd0, 1'b0, 48'd0, 2'd0, 2'd0, 16'd0);
    insert(16'd3, 48'h5000, 2'd1, 2'd3, 48'h55000, 2'd3);
    insert(16'd3, 48'h0, 2'd1, 2'd2, 48'h600000, 2'd1);
    inv(2'd2, 16'd3, 1'b1, 48'h5000, 2'd1, 2'd3, 16'd1);
    lookup(16'd3, 48'h5000, 2'd1, 2'd3);
    lookup(16'd3, 48'h5000, 2'd1, 2'd2); idle(3);

    cur_req = "R9";
    inv(2'd0, 16'd0, 1'b0, 48'd0, 2'd0, 2'd0, 16'd0);
    insert(16'd4, 48'h10000, 2'd1, 2'd3, 48'hA1000, 2'd3);
    insert(16'd4, 48'h13000, 2'd1, 2'd3, 48'hA2000, 2'd3);
    insert(16'd7, 48'h11000, 2'd1, 2'd3, 48'hA3000, 2'd3);
    insert(16'd4, 48'h200000, 2'd1, 2'd2, 48'hA00000, 2'd3);
    inv(2'd2, 16'd4, 1'b0, 48'h10000, 2'd0, 2'd0, 16'd2);
    lookup(16'd4, 48'h10000, 2'd1, 2'd3);
    lookup(16'd4, 48'h13000, 2'd1, 2'd3);
    lookup(16'd7, 48'h11000, 2'd1, 2'd3);
    lookup(16'd4, 48'h200000, 2'd1, 2'd2); idle(3);
    insert(16'd9, 48'h400000, 2'd1, 2'd3, 48'hB0000, 2'd1);
    inv(2'd2, 16'd0, 1'b1, 48'h0, 2'd1, 2'd0, 16'h400);
    lookup(16'd4, 48'h13000, 2'd1, 2'd3);
    lookup(16'd7, 48'h11000, 2'd1, 2'd3);
    lookup(16'd4, 48'h200000, 2'd1, 2'd2);
    lookup(16'd9, 48'h400000, 2'd1, 2'd3); idle(3);
    inv(2'd3, 16'd9, 1'b1, 48'h0, 2'd0, 2'd0, 16'd0);
    lookup(16'd9, 48'h400000, 2'd1, 2'd3); idle(3);

    cur_req = "R10";
    inv_go(2'd1, 16'd1, 1'b0, 48'd0, 2'd0, 2'd0, 16'd0);
    lookup(16'd9, 48'h400000, 2'd1, 2'd3); idle(3);

    cur_req = "R12";
    fork
      inv_go(2'd0, 16'd0, 1'b0, 48'd0, 2'd0, 2'd0, 16'd0);
      insert(16'd12, 48'hC000, 2'd1, 2'd3, 48'hCC000, 2'd2);
      lookup(16'd12, 48'hC000, 2'd1, 2'd3);
    join
    idle(3);

    cur_req = "R11";
    for (int i = 0; i < 20; i++) lookup(16'd12, 48'hC000, 2'd1, 2'd3);
    for (int i = 0; i < 20; i++) lookup(16'd13, 48'hC000, 2'd1, 2'd3);
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule